// File: doc/BRIEF.md
# Serial Comma Word Aligner

This block sits behind a clock-recovery stage that hands over one serial bit per clock. It groups the bits into 10-bit words. When alignment is enabled, it moves the word boundary so that every 7-bit comma prefix `0011111` starts a word. The comma bits are listed here in the order they are received. Each word is output with the earliest received bit in bit 0.

With every word the block also outputs a sync level and a pair of complementary strobes that run at half the word rate. The sync level marks a comma word and stays valid until the next word. The strobes toggle once per word. A comma word always makes `strobe_b` rise, or holds it high if it is already high. The strobes never move between words, so while the boundary is being shifted they keep their current level.

The bit stream uses a valid-only handshake. There is no ready on either side: the block accepts every bit offered with `bit_valid`, and the downstream logic must accept every word in the cycle that `word_valid` is high. A cycle with `bit_valid` low does not advance the stream.

Top module: `comma_word_aligner`

## Requirements
- R1: During and right after reset, `word_valid`=0, `sync_flag`=0, `word_data`=0, `strobe_a`=1 and `strobe_b`=0. The boundary counter starts at word position 0.
- R2: With `align_en` low, a word is output after every 10 accepted bits, counted from the first bit accepted after reset. `word_data[i]` holds the i-th received bit of that word.
- R3: With `align_en` low, a comma never changes the boundary and `sync_flag` stays 0.
- R4: A cycle with `bit_valid` low is ignored: no bit enters the window and no word is emitted on the following cycle.
- R5: With `align_en` high, a comma that starts on the current boundary leaves the boundary unchanged. It is output as one word with `word_data[6:0]`=`7'b1111100` and `sync_flag`=1.
- R6: With `align_en` high, a comma that straddles the boundary moves the boundary. The word that completes before the comma's last bit is output holding stray bits. The partial word in progress when the comma completes is dropped. The comma word itself and all later words come out on the new boundary.
- R7: `sync_flag` changes only when a word is emitted. It is 1 from the comma word until the next word is emitted.
- R8: `strobe_a` and `strobe_b` are always complementary. Every non-comma word emission toggles both of them.
- R9: A comma word leaves `strobe_b`=1. If `strobe_b` was already 1, it stays high for one more word period instead of falling.
- R10: The strobes change only in a cycle where `word_valid` is 1. They hold their level while a realignment is in progress.
- R11: `word_valid` is a one-cycle pulse in the cycle that follows the clock edge on which the word's last bit was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_en | input | 1 | Enables comma-driven boundary moves and the sync flag |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial data bit |
| word_valid | output | 1 | One-cycle pulse marking a new word |
| word_data | output | WORD_W | Aligned word; bit 0 was received first |
| sync_flag | output | 1 | Set for a comma word; held until the next word |
| strobe_a | output | 1 | Half-word-rate strobe, inverse of `strobe_b` |
| strobe_b | output | 1 | Half-word-rate strobe that rises with a comma word |

## Verification
The bench builds the block with its default values: a 10-bit word and a 7-bit comma, with the comma's first bit in bit 0. With these values the comma can land at hand-computed offsets: on the boundary, four bits past it and seven bits past it. Each of these offsets gives a different stray word and a different drop length. Back-to-back commas bring the held-high case of `strobe_b` within reach. Idle cycles with ones on `bit_in` show that gaps in the stream cannot create a false comma.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  localparam int WORD_W  = 10;
  localparam int COMMA_W = 7;
  // Comma prefix, earliest received bit in bit 0: 0,0,1,1,1,1,1
  localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/cwa_window.sv
module cwa_window #(
  parameter int WORD_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] win_next,
  output logic              comma_hit
);
  logic [WORD_W-1:0] win_q;

  // newest bit enters at the top, so the oldest bit sits in bit 0
  assign win_next  = {bit_in, win_q[WORD_W-1:1]};
  assign comma_hit = shift_en && (win_next[WORD_W-1 -: COMMA_W] == COMMA_PAT);

  always_ff @(posedge clk) begin
    if (!rst_n)        win_q <= '0;
    else if (shift_en) win_q <= win_next;
  end
endmodule

// File: rtl/cwa_framer.sv
module cwa_framer #(
  parameter int WORD_W = 10,
  parameter int COMMA_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic comma_hit,
  input  logic align_en,
  output logic emit,
  output logic comma_word
);
  localparam int PW = $clog2(WORD_W);
  localparam logic [PW-1:0] LAST_POS   = PW'(WORD_W - 1);
  localparam logic [PW-1:0] RESUME_POS = PW'(COMMA_W);

  logic [PW-1:0] pos_q;
  logic          pend_q;
  logic          hit_en;

  assign hit_en     = comma_hit && align_en;
  assign emit       = shift_en && (pos_q == LAST_POS) && !hit_en;
  assign comma_word = pend_q && align_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      pend_q <= 1'b0;
    end else if (shift_en) begin
      if (hit_en) begin
        // the comma's last bit defines the word position COMMA_W-1
        pos_q  <= RESUME_POS;
        pend_q <= 1'b1;
      end else if (pos_q == LAST_POS) begin
        pos_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        pos_q  <= pos_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/cwa_strobes.sv
module cwa_strobes #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic              comma_word,
  input  logic [WORD_W-1:0] win_next,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              sync_flag,
  output logic              strobe_a,
  output logic              strobe_b
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
      sync_flag  <= 1'b0;
      strobe_a   <= 1'b1;
      strobe_b   <= 1'b0;
    end else begin
      word_valid <= emit;
      if (emit) begin
        word_data <= win_next;
        sync_flag <= comma_word;
        if (comma_word) begin
          strobe_a <= 1'b0;
          strobe_b <= 1'b1;
        end else begin
          strobe_a <= strobe_b;
          strobe_b <= strobe_a;
        end
      end
    end
  end
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int WORD_W = cwa_pkg::WORD_W,
  parameter int COMMA_W = cwa_pkg::COMMA_W,
  parameter logic [COMMA_W-1:0] COMMA_PAT = cwa_pkg::COMMA_PAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              align_en,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              sync_flag,
  output logic              strobe_a,
  output logic              strobe_b
);
  logic [WORD_W-1:0] win_next;
  logic              comma_hit;
  logic              emit;
  logic              comma_word;

  cwa_window #(.WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_window (
    .clk(clk), .rst_n(rst_n), .shift_en(bit_valid), .bit_in(bit_in),
    .win_next(win_next), .comma_hit(comma_hit)
  );

  cwa_framer #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .shift_en(bit_valid), .comma_hit(comma_hit),
    .align_en(align_en), .emit(emit), .comma_word(comma_word)
  );

  cwa_strobes #(.WORD_W(WORD_W)) u_strobes (
    .clk(clk), .rst_n(rst_n), .emit(emit), .comma_word(comma_word),
    .win_next(win_next), .word_valid(word_valid), .word_data(word_data),
    .sync_flag(sync_flag), .strobe_a(strobe_a), .strobe_b(strobe_b)
  );
endmodule

// File: rtl/cwa_checker.sv
module cwa_checker #(
  parameter int WORD_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              align_en,
  input logic              bit_valid,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              sync_flag,
  input logic              strobe_a,
  input logic              strobe_b
);
  AST_STROBE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_a != strobe_b); // R8
  AST_STROBE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !sync_flag |-> strobe_b != $past(strobe_b)); // R8
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(strobe_b)); // R10
  AST_COMMA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && sync_flag |-> strobe_b); // R9
  AST_COMMA_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && sync_flag |-> word_data[COMMA_W-1:0] == COMMA_PAT); // R5
  AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag) |-> word_valid); // R7
  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(sync_flag)); // R7
  AST_NO_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !$past(align_en) |-> !sync_flag); // R3
  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_valid) |-> !word_valid); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R11
endmodule

bind comma_word_aligner cwa_checker #(.WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .align_en(align_en), .bit_valid(bit_valid),
  .word_valid(word_valid), .word_data(word_data), .sync_flag(sync_flag),
  .strobe_a(strobe_a), .strobe_b(strobe_b)
);

// File: tb/tb_comma_word_aligner.sv
`timescale 1ns/1ps
module tb_comma_word_aligner;
  localparam int W = 10;
  localparam logic [W-1:0] COMMA = 10'h17C; // 0011111010, first bit in bit 0

  logic clk = 1'b0, rst_n = 1'b0, align_en = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic word_valid, sync_flag, strobe_a, strobe_b;
  logic [W-1:0] word_data;

  int checks = 0, errors = 0;
  logic exp_b = 1'b0;
  logic prev_valid = 1'b0;
  logic [W+1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  comma_word_aligner dut (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .bit_valid(bit_valid), .bit_in(bit_in),
    .word_valid(word_valid), .word_data(word_data), .sync_flag(sync_flag),
    .strobe_a(strobe_a), .strobe_b(strobe_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [W-1:0] d, input logic s, input string req);
    exp_b = s ? 1'b1 : ~exp_b;
    exp_q.push_back({d, s, exp_b});
    tag_q.push_back(req);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in = 1'b1;
    end
  endtask

  task automatic send_word(input logic [W-1:0] d, input logic gappy);
    for (int i = 0; i < W; i++) begin
      send_bit(d[i]);
      if (gappy) idle(2);
    end
  endtask

  task automatic send_raw(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) send_bit(bits[i]);
  endtask

  // monitor: pops the scoreboard whenever a word appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin
        chk("R11 valid pulse width", {31'd0, prev_valid}, 32'd0);
        chk("R8 strobes complementary", {31'd0, strobe_a}, {31'd0, ~strobe_b});
        if (exp_q.size() == 0) begin
          chk("R2 unexpected word", {22'd0, word_data}, 32'hFFFF_FFFF);
        end else begin
          logic [W+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " data"}, {22'd0, word_data}, {22'd0, e[W+1:2]});
          chk({t, " sync R7"}, {31'd0, sync_flag}, {31'd0, e[1]});
          chk({t, " strobe R9"}, {31'd0, strobe_b}, {31'd0, e[0]});
        end
      end
      prev_valid <= word_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 word_valid", {31'd0, word_valid}, 32'd0);
    chk("R1 sync_flag", {31'd0, sync_flag}, 32'd0);
    chk("R1 word_data", {22'd0, word_data}, 32'd0);
    chk("R1 strobe_a", {31'd0, strobe_a}, 32'd1);
    chk("R1 strobe_b", {31'd0, strobe_b}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobe_a after reset", {31'd0, strobe_a}, 32'd1);

    // alignment off: fixed boundary, no sync
    expect_word(10'h2AA, 1'b0, "R2"); send_word(10'h2AA, 1'b0);
    expect_word(10'h155, 1'b0, "R2"); send_word(10'h155, 1'b0);
    expect_word(10'h333, 1'b0, "R2"); send_word(10'h333, 1'b0);
    expect_word(COMMA, 1'b0, "R3 aligned comma ignored"); send_word(COMMA, 1'b0);
    expect_word(10'h3E5, 1'b0, "R3 straddling comma ignored");
    expect_word(10'h152, 1'b0, "R3 boundary kept");
    send_raw(32'b101, 3); send_word(COMMA, 1'b0); send_raw(32'b0101010, 7);

    // idle cycles carry ones on bit_in and must be ignored
    expect_word(10'h2AA, 1'b0, "R4 gaps off"); send_word(10'h2AA, 1'b1);
    align_en = 1'b1;
    expect_word(10'h155, 1'b0, "R4 gaps on"); send_word(10'h155, 1'b1);

    // comma on the boundary; strobe_b rises with it
    expect_word(COMMA, 1'b1, "R5 aligned comma"); send_word(COMMA, 1'b0);
    idle(5);
    chk("R7 sync held between words", {31'd0, sync_flag}, 32'd1);
    chk("R10 strobe held between words", {31'd0, strobe_b}, 32'd1);
    // second comma: strobe_b already high, so it is stretched
    expect_word(COMMA, 1'b1, "R9 stretched comma"); send_word(COMMA, 1'b0);
    expect_word(10'h2AA, 1'b0, "R7 sync cleared"); send_word(10'h2AA, 1'b0);

    // comma four bits past the boundary
    expect_word(10'h3C5, 1'b0, "R6 stray word offset4");
    expect_word(COMMA, 1'b1, "R6 realigned comma offset4");
    expect_word(10'h2AA, 1'b0, "R6 after realign");
    expect_word(10'h155, 1'b0, "R6 after realign");
    send_raw(32'b0101, 4); send_word(COMMA, 1'b0);
    send_word(10'h2AA, 1'b0); send_word(10'h155, 1'b0);

    // comma seven bits past the boundary
    expect_word(10'h255, 1'b0, "R6 stray word offset7");
    expect_word(COMMA, 1'b1, "R6 realigned comma offset7");
    expect_word(10'h333, 1'b0, "R6 after realign");
    send_raw(32'b1010101, 7); send_word(COMMA, 1'b0); send_word(10'h333, 1'b0);

    // alignment off again: boundary must not follow the comma
    align_en = 1'b0;
    expect_word(10'h3E5, 1'b0, "R3 disabled again");
    expect_word(10'h152, 1'b0, "R3 disabled again");
    send_raw(32'b101, 3); send_word(COMMA, 1'b0); send_raw(32'b0101010, 7);

    idle(20);
    chk("R2 all expected words seen", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule